// File: doc/BRIEF.md
# Multi-Issue Dispatch Scoreboard

This block is the in-order dispatch stage of a multi-issue core. Each cycle it looks at up to four decoded instructions at the head of the instruction queue. Every instruction names one destination register, two source registers and the class of functional unit it needs. The block keeps one pending bit per architectural register. The bit marks a register that an issued instruction will write but has not yet written back. From these bits, from the group itself and from the busy flags of the six functional units, it decides how many leading instructions issue this cycle. It also names the unit that each issued instruction goes to.

Writeback ports clear pending bits as results retire. An exception flush clears the bits of every squashed instruction, so that a faulting write leaves its destination untouched. Issue stalls for the whole flush cycle. The issue decision is combinational within the cycle. The pending bits change on the next clock edge.

Top module: `issue_scoreboard`

## Requirements
- R1: After reset every pending bit is 0, and with no valid slot the issue count is 0.
- R2: The issue count is the length of the leading run of slots that can issue, from 0 to 4. The first slot that is invalid or blocked ends the group, and no later slot issues in that cycle.
- R3: A slot does not issue while either of its source registers is pending (read after write).
- R4: A slot does not issue while its destination register is pending (write after write).
- R5: A slot does not issue if one of its sources or its destination equals the non-zero destination of an earlier slot in the same group.
- R6: Register 0 never becomes pending and never blocks a slot, whether as a source, as a destination or inside a group.
- R7: Unit classes are encoded 0 branch, 1 load/store, 2 integer and 3 floating point. Unit indices are 0 branch, 1 load/store, 2 to 4 integer and 5 floating point. A slot issues only if a unit of its class is free, meaning not busy and not taken by an earlier slot of the group. It receives the lowest such index.
- R8: The non-zero destination of every issued slot reads as pending from the next cycle on.
- R9: A valid writeback port clears the pending bit of its register at the next edge. If an issue sets the same register in the same cycle, the bit stays set.
- R10: While flush is high the issue count is 0, and every register set in the flush mask is cleared at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_valid | input | 4 | Slot holds a decoded instruction |
| slot_dst | input | 4x5 | Destination register per slot |
| slot_srca | input | 4x5 | First source register per slot |
| slot_srcb | input | 4x5 | Second source register per slot |
| slot_cls | input | 4x2 | Functional-unit class per slot |
| unit_busy | input | 6 | Busy flag per functional unit |
| wb_valid | input | 4 | Writeback port active |
| wb_reg | input | 4x5 | Register retired on each writeback port |
| flush | input | 1 | Exception flush this cycle |
| flush_mask | input | 32 | Destinations of the squashed instructions |
| issue_count | output | 3 | Number of leading slots issued this cycle |
| issue_unit | output | 4x3 | Unit index per slot; 7 when the slot does not issue |
| sb_pending | output | 32 | Pending bit per register |

## Verification
Two events can meet in one cycle: a writeback clear and an issue set that land on the same register, and a flush that coincides with a fully issuable group. The bench provokes the first by retiring a register that is not pending while a slot writes that register. It checks that the bit reads set one cycle later. For the second it raises flush while a group is ready to issue. It expects a count of zero and then checks that only the masked bits have dropped. A long random sweep over eight registers also mixes writebacks, flushes and busy units, and compares every cycle with an arithmetic model written in the bench.

// File: rtl/isb_pkg.sv
package isb_pkg;
  localparam int NSLOT = 4;
  localparam int NREG  = 32;
  localparam int RW    = $clog2(NREG);
  localparam int NWB   = 4;
  localparam int N_BR  = 1;
  localparam int N_LS  = 1;
  localparam int N_INT = 3;
  localparam int N_FP  = 1;
  localparam int NUNIT = N_BR + N_LS + N_INT + N_FP;
  localparam int UW    = $clog2(NUNIT + 1);
  localparam int CW    = $clog2(NSLOT + 1);

  localparam logic [1:0] CLS_BR  = 2'd0;
  localparam logic [1:0] CLS_LS  = 2'd1;
  localparam logic [1:0] CLS_INT = 2'd2;
  localparam logic [1:0] CLS_FP  = 2'd3;

  localparam logic [UW-1:0] NO_UNIT = '1;

  // class served by unit index u
  function automatic logic [1:0] unit_cls(int u);
    if (u < N_BR) return CLS_BR;
    else if (u < N_BR + N_LS) return CLS_LS;
    else if (u < N_BR + N_LS + N_INT) return CLS_INT;
    else return CLS_FP;
  endfunction

  // k-th (from 0) free unit of class c, lowest index first
  function automatic logic [UW-1:0] pick_unit(logic [1:0] c, int k,
                                               logic [NUNIT-1:0] busy);
    logic [UW-1:0] res;
    int seen;
    res  = NO_UNIT;
    seen = 0;
    for (int u = 0; u < NUNIT; u++) begin
      if (unit_cls(u) == c && !busy[u]) begin
        if (seen == k && res == NO_UNIT) res = UW'(u);
        seen++;
      end
    end
    return res;
  endfunction

  // register r is pending in vec (register 0 never counts)
  function automatic logic reg_hit(logic [RW-1:0] r, logic [NREG-1:0] vec);
    return (r != '0) && vec[r];
  endfunction
endpackage

// File: rtl/isb_state.sv
module isb_state
  import isb_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREG-1:0] set_vec,
  input  logic [NREG-1:0] clr_vec,
  output logic [NREG-1:0] pending
);
  always_ff @(posedge clk) begin
    if (!rst_n) pending <= '0;
    else        pending <= (pending & ~clr_vec) | set_vec;
  end
endmodule

// File: rtl/isb_hazard.sv
module isb_hazard
  import isb_pkg::*;
(
  input  logic [NREG-1:0]          pending,
  input  logic [NSLOT-1:0][RW-1:0] slot_dst,
  input  logic [NSLOT-1:0][RW-1:0] slot_srca,
  input  logic [NSLOT-1:0][RW-1:0] slot_srcb,
  output logic [NSLOT-1:0]         grp_hazard
);
  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    logic sb_hit;
    logic grp_hit;
    assign sb_hit = reg_hit(slot_srca[i], pending) | reg_hit(slot_srcb[i], pending)
                  | reg_hit(slot_dst[i], pending);
    always_comb begin
      grp_hit = 1'b0;
      for (int j = 0; j < i; j++) begin
        if (slot_dst[j] != '0 &&
            (slot_srca[i] == slot_dst[j] || slot_srcb[i] == slot_dst[j] ||
             slot_dst[i] == slot_dst[j]))
          grp_hit = 1'b1;
      end
    end
    assign grp_hazard[i] = sb_hit | grp_hit;
  end
endmodule

// File: rtl/isb_alloc.sv
module isb_alloc
  import isb_pkg::*;
(
  input  logic [NSLOT-1:0][1:0]    slot_cls,
  input  logic [NUNIT-1:0]         unit_busy,
  output logic [NSLOT-1:0][UW-1:0] unit_pick,
  output logic [NSLOT-1:0]         unit_ok
);
  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    int rank;
    always_comb begin
      rank = 0;
      for (int j = 0; j < i; j++)
        if (slot_cls[j] == slot_cls[i]) rank++;
    end
    assign unit_pick[i] = pick_unit(slot_cls[i], rank, unit_busy);
    assign unit_ok[i]   = unit_pick[i] != NO_UNIT;
  end
endmodule

// File: rtl/issue_scoreboard.sv
module issue_scoreboard
  import isb_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSLOT-1:0]         slot_valid,
  input  logic [NSLOT-1:0][RW-1:0] slot_dst,
  input  logic [NSLOT-1:0][RW-1:0] slot_srca,
  input  logic [NSLOT-1:0][RW-1:0] slot_srcb,
  input  logic [NSLOT-1:0][1:0]    slot_cls,
  input  logic [NUNIT-1:0]         unit_busy,
  input  logic [NWB-1:0]           wb_valid,
  input  logic [NWB-1:0][RW-1:0]   wb_reg,
  input  logic                     flush,
  input  logic [NREG-1:0]          flush_mask,
  output logic [CW-1:0]            issue_count,
  output logic [NSLOT-1:0][UW-1:0] issue_unit,
  output logic [NREG-1:0]          sb_pending
);
  logic [NREG-1:0]          pending;
  logic [NREG-1:0]          set_vec;
  logic [NREG-1:0]          clr_vec;
  logic [NSLOT-1:0]         grp_hazard;
  logic [NSLOT-1:0]         unit_ok;
  logic [NSLOT-1:0][UW-1:0] unit_pick;
  logic [NSLOT-1:0]         slot_ok;
  logic [NSLOT-1:0]         issue_go;

  isb_state u_state (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .pending (pending)
  );

  isb_hazard u_hazard (
    .pending    (pending),
    .slot_dst   (slot_dst),
    .slot_srca  (slot_srca),
    .slot_srcb  (slot_srcb),
    .grp_hazard (grp_hazard)
  );

  isb_alloc u_alloc (
    .slot_cls  (slot_cls),
    .unit_busy (unit_busy),
    .unit_pick (unit_pick),
    .unit_ok   (unit_ok)
  );

  assign slot_ok = slot_valid & ~grp_hazard & unit_ok & {NSLOT{~flush}};

  // in-order prefix: a slot goes only if every earlier slot goes
  always_comb begin
    logic run;
    run = 1'b1;
    for (int i = 0; i < NSLOT; i++) begin
      run         = run & slot_ok[i];
      issue_go[i] = run;
    end
  end

  always_comb begin
    set_vec = '0;
    for (int i = 0; i < NSLOT; i++)
      if (issue_go[i]) set_vec[slot_dst[i]] = 1'b1;
    set_vec[0] = 1'b0;
  end

  always_comb begin
    clr_vec = flush ? flush_mask : '0;
    for (int w = 0; w < NWB; w++)
      if (wb_valid[w]) clr_vec[wb_reg[w]] = 1'b1;
  end

  for (genvar i = 0; i < NSLOT; i++) begin : g_out
    assign issue_unit[i] = issue_go[i] ? unit_pick[i] : NO_UNIT;
  end

  assign issue_count = CW'($countones(issue_go));
  assign sb_pending  = pending;
endmodule

// File: rtl/isb_checker.sv
module isb_checker
  import isb_pkg::*;
(
  input logic                     clk,
  input logic                     rst_n,
  input logic                     flush,
  input logic [NSLOT-1:0][RW-1:0] slot_dst,
  input logic [NSLOT-1:0][RW-1:0] slot_srca,
  input logic [NSLOT-1:0][RW-1:0] slot_srcb,
  input logic [NUNIT-1:0]         unit_busy,
  input logic [NSLOT-1:0]         issue_go,
  input logic [CW-1:0]            issue_count,
  input logic [NSLOT-1:0][UW-1:0] issue_unit,
  input logic [NREG-1:0]          pending
);
  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) issue_count <= CW'(NSLOT)); // R2
  AST_REG0_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !pending[0]); // R6
  AST_FLUSH_HOLD: assert property (@(posedge clk) disable iff (!rst_n) flush |-> issue_count == '0); // R10

  for (genvar i = 0; i < NSLOT; i++) begin : g_chk
    AST_NO_RAW: assert property (@(posedge clk) disable iff (!rst_n)
      issue_go[i] |-> !reg_hit(slot_srca[i], pending) && !reg_hit(slot_srcb[i], pending)); // R3
    AST_NO_WAW: assert property (@(posedge clk) disable iff (!rst_n)
      issue_go[i] |-> !reg_hit(slot_dst[i], pending)); // R4
    AST_UNIT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      issue_go[i] |-> issue_unit[i] < UW'(NUNIT) && !unit_busy[issue_unit[i]]); // R7
    AST_DST_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
      issue_go[i] && slot_dst[i] != '0 |=> pending[$past(slot_dst[i])]); // R8
    if (i > 0) begin : g_pre
      AST_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        issue_go[i] |-> issue_go[i-1]); // R2
    end
    for (genvar j = 0; j < i; j++) begin : g_pair
      AST_UNIT_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
        issue_go[i] && issue_go[j] |-> issue_unit[i] != issue_unit[j]); // R7
    end
  end
endmodule

bind issue_scoreboard isb_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .flush       (flush),
  .slot_dst    (slot_dst),
  .slot_srca   (slot_srca),
  .slot_srcb   (slot_srcb),
  .unit_busy   (unit_busy),
  .issue_go    (issue_go),
  .issue_count (issue_count),
  .issue_unit  (issue_unit),
  .pending     (pending)
);

// File: tb/issue_scoreboard_tb.sv
`timescale 1ns/1ps
module issue_scoreboard_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic [3:0]      slot_valid;
  logic [3:0][4:0] slot_dst, slot_srca, slot_srcb;
  logic [3:0][1:0] slot_cls;
  logic [5:0]      unit_busy;
  logic [3:0]      wb_valid;
  logic [3:0][4:0] wb_reg;
  logic            flush;
  logic [31:0]     flush_mask;
  logic [2:0]      issue_count;
  logic [3:0][2:0] issue_unit;
  logic [31:0]     sb_pending;

  int checks = 0;
  int errors = 0;
  logic [31:0]     m_pend;
  int              e_cnt;
  logic [3:0][2:0] e_unit;
  logic [31:0]     e_set;

  always #2 clk = ~clk;

  issue_scoreboard u_dut (.*);

  initial begin
    #(4 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic int cls_of_unit(int u);
    case (u)
      0: return 0;
      1: return 1;
      5: return 3;
      default: return 2;
    endcase
  endfunction

  // reference issue decision: greedy scan over slots and units
  function automatic int model_issue(output logic [3:0][2:0] eu, output logic [31:0] es);
    logic [5:0]  taken;
    logic [31:0] blk;
    int n, found;
    bit stop, ok;
    taken = unit_busy; blk = m_pend; n = 0; stop = 0;
    eu = '1; es = '0;
    for (int s = 0; s < 4; s++) begin
      if (!stop) begin
        ok = slot_valid[s] && !flush;
        if (slot_srca[s] != 0 && blk[slot_srca[s]]) ok = 0;
        if (slot_srcb[s] != 0 && blk[slot_srcb[s]]) ok = 0;
        if (slot_dst[s]  != 0 && blk[slot_dst[s]])  ok = 0;
        found = -1;
        for (int u = 0; u < 6; u++)
          if (found < 0 && !taken[u] && cls_of_unit(u) == int'(slot_cls[s])) found = u;
        if (found < 0) ok = 0;
        if (ok) begin
          taken[found] = 1'b1;
          eu[s] = 3'(found);
          if (slot_dst[s] != 0) begin blk[slot_dst[s]] = 1'b1; es[slot_dst[s]] = 1'b1; end
          n++;
        end else stop = 1;
      end
    end
    return n;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    slot_valid = '0; slot_dst = '0; slot_srca = '0; slot_srcb = '0; slot_cls = '0;
    unit_busy = '0; wb_valid = '0; wb_reg = '0; flush = 0; flush_mask = '0;
  endtask

  task automatic put(int s, int d, int a, int b, int c);
    slot_valid[s] = 1'b1; slot_dst[s] = 5'(d); slot_srca[s] = 5'(a);
    slot_srcb[s] = 5'(b); slot_cls[s] = 2'(c);
  endtask

  task automatic settle(string tag);
    #1;
    e_cnt = model_issue(e_unit, e_set);
    chk(tag, "count", 32'(issue_count), 32'(e_cnt));
    for (int s = 0; s < 4; s++)
      if (s < e_cnt) chk(tag, "unit", 32'(issue_unit[s]), 32'(e_unit[s]));
  endtask

  task automatic tick(string tag);
    logic [31:0] c;
    c = flush ? flush_mask : '0;
    for (int w = 0; w < 4; w++) if (wb_valid[w]) c[wb_reg[w]] = 1'b1;
    @(posedge clk);
    m_pend = (m_pend & ~c) | e_set;
    m_pend[0] = 1'b0;
    @(negedge clk);
    chk(tag, "pending", sb_pending, m_pend);
  endtask

  initial begin
    idle(); rst_n = 0; m_pend = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    #1;
    chk("R1", "pending", sb_pending, 0);
    chk("R1", "count", 32'(issue_count), 0);
    @(negedge clk);

    // R6 register 0 as source and destination, also inside the group
    idle(); put(0, 0, 0, 0, 2); put(1, 0, 0, 0, 2);
    settle("R6"); chk("R6", "count", 32'(issue_count), 2); tick("R6");
    chk("R6", "pending", sb_pending, 0);

    // R8 issued destination becomes pending
    idle(); put(0, 5, 1, 2, 2);
    settle("R8"); chk("R8", "unit", 32'(issue_unit[0]), 2); tick("R8");
    chk("R8", "p5", 32'(sb_pending[5]), 1);

    // R3 source pending blocks
    idle(); put(0, 6, 5, 0, 2);
    settle("R3"); chk("R3", "count", 32'(issue_count), 0); tick("R3");
    // R4 destination pending blocks
    idle(); put(0, 5, 1, 2, 2);
    settle("R4"); chk("R4", "count", 32'(issue_count), 0); tick("R4");

    // R9 set and clear of register 7 in the same cycle: set wins
    idle(); put(0, 7, 1, 2, 2); wb_valid[0] = 1; wb_reg[0] = 7;
    settle("R9"); chk("R9", "count", 32'(issue_count), 1); tick("R9");
    chk("R9", "p7", 32'(sb_pending[7]), 1);
    idle(); wb_valid = 4'b0011; wb_reg[0] = 5; wb_reg[1] = 7;
    settle("R9"); tick("R9");
    chk("R9", "cleared", sb_pending, 0);

    // R2 full group of four, one per class
    idle(); put(0, 1, 0, 0, 0); put(1, 2, 0, 0, 1); put(2, 3, 0, 0, 2); put(3, 4, 0, 0, 3);
    settle("R2"); chk("R2", "count", 32'(issue_count), 4);
    chk("R2", "fp unit", 32'(issue_unit[3]), 5); tick("R2");
    idle(); wb_valid = 4'hf; wb_reg[0] = 1; wb_reg[1] = 2; wb_reg[2] = 3; wb_reg[3] = 4;
    settle("R9"); tick("R9");
    // R2 invalid slot ends the group
    idle(); put(0, 0, 0, 0, 2); put(2, 0, 0, 0, 2);
    settle("R2"); chk("R2", "gap", 32'(issue_count), 1);
    chk("R2", "unit2", 32'(issue_unit[2]), 7); tick("R2");

    // R5 intra-group dependence on source and destination
    idle(); put(0, 9, 0, 0, 2); put(1, 10, 0, 9, 2);
    settle("R5"); chk("R5", "src", 32'(issue_count), 1); tick("R5");
    idle(); wb_valid[0] = 1; wb_reg[0] = 9; settle("R5"); tick("R5");
    idle(); put(0, 9, 0, 0, 2); put(1, 9, 0, 0, 2);
    settle("R5"); chk("R5", "dst", 32'(issue_count), 1); tick("R5");
    idle(); wb_valid[0] = 1; wb_reg[0] = 9; settle("R5"); tick("R5");

    // R7 unit allocation with a busy integer unit
    idle(); put(0, 0, 0, 0, 2); put(1, 0, 0, 0, 2); put(2, 0, 0, 0, 2); unit_busy[3] = 1;
    settle("R7"); chk("R7", "count", 32'(issue_count), 2);
    chk("R7", "u0", 32'(issue_unit[0]), 2); chk("R7", "u1", 32'(issue_unit[1]), 4); tick("R7");
    idle(); for (int s = 0; s < 4; s++) put(s, 0, 0, 0, 2);
    settle("R7"); chk("R7", "int cap", 32'(issue_count), 3); tick("R7");
    idle(); put(0, 0, 0, 0, 3); unit_busy[5] = 1;
    settle("R7"); chk("R7", "fp busy", 32'(issue_count), 0); tick("R7");

    // R10 flush stalls issue and clears masked bits
    idle(); put(0, 10, 0, 0, 2); put(1, 11, 0, 0, 2);
    settle("R10"); tick("R10");
    idle(); put(0, 12, 0, 0, 2); flush = 1; flush_mask = 32'h0000_0400;
    settle("R10"); chk("R10", "stall", 32'(issue_count), 0); tick("R10");
    chk("R10", "mask", sb_pending, 32'h0000_0800);

    // R2 R7 R9 sweep over eight registers
    for (int n = 0; n < 3000; n++) begin
      idle();
      for (int s = 0; s < 4; s++)
        if ($urandom % 5 != 0)
          put(s, int'($urandom % 8), int'($urandom % 8), int'($urandom % 8), int'($urandom % 4));
      unit_busy = 6'($urandom) & 6'($urandom);
      for (int w = 0; w < 4; w++) begin
        wb_valid[w] = 1'($urandom % 2);
        wb_reg[w] = 5'($urandom % 8);
      end
      if ($urandom % 16 == 0) begin flush = 1; flush_mask = 32'($urandom % 256); end
      settle("R2");
      tick("R9");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule